// File: doc/BRIEF.md
# Immediate-Operand Execute Unit

This block carries out one family of 16-bit compact instructions, in which a low general-purpose register is combined with an 8-bit literal. It holds eight 32-bit registers and four condition flags: negative, zero, carry and overflow. A two-bit operation field picks one of four actions. Move loads the literal. Add and subtract update the register in place. Compare sets only the flags.

An instruction is offered with a one-cycle valid strobe. Its effect on the register file and the flags is visible right after the next rising clock edge. Words that do not carry this family's three-bit tag are refused: a registered illegal pulse is raised and no state changes. A separate read-select input lets the surrounding logic or a bench observe any register, and the flags are always driven out.

Top module: `imm_exec_unit`

## Requirements
- R1: A synchronous active-high reset sets all eight registers to zero, the flags output to zero and the illegal output low.
- R2: An instruction is legal only when bits [15:13] equal 001. A strobed word with any other tag drives illegal high in the following cycle and leaves every register and every flag unchanged. A strobed legal word, or a cycle with no strobe, leaves illegal low in the following cycle.
- R3: Operation code 0 (bits [12:11]) is move. It writes the literal into the selected register, sets N to bit 31 of that value and Z when the value is zero, and keeps C and V at their old values.
- R4: Operation code 2 is add. It writes register plus literal, sets N and Z from the sum, sets C to the carry out of bit 31, and sets V on signed overflow.
- R5: Operation code 3 is subtract. It writes register minus literal and sets N and Z from the difference. C is set when no borrow occurs, meaning the register is not below the literal when both are read as unsigned. V is set on signed overflow.
- R6: Operation code 1 is compare. It sets the flags exactly as subtract would and never writes the register.
- R7: Bits [10:8] choose the register to read and write, and no other register changes.
- R8: While the valid strobe is low, neither registers nor flags change, whatever the instruction input holds.
- R9: Bits [7:0] are an unsigned literal, zero-extended to 32 bits, so 128 and 255 act as positive values.
- R10: A new instruction may be strobed in every cycle, and each one sees the result of the one before it.
- R11: The flags output packs N at bit 3, Z at bit 2, C at bit 1 and V at bit 0. The read port returns the register chosen by the read select without any clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe marking in_instr as an instruction to execute |
| in_instr | input | 16 | Instruction word |
| illegal | output | 1 | Registered pulse for a strobed word with a wrong tag |
| rd_sel | input | 3 | Register chosen for the read port |
| rd_data | output | 32 | Contents of the register chosen by rd_sel |
| flags_o | output | 4 | Condition flags {N, Z, C, V} |

## Verification
The bench builds the block with the package defaults: a 16-bit instruction word, eight 32-bit registers and an 8-bit literal. With those values it can reach every register select, the literal extremes 0, 128 and 255, and 32-bit wraparound. Subtracting a larger literal gives negative results and clears carry, and adding back across zero sets carry with a zero result. Signed overflow needs operands near the 2^31 boundary, which short literal-only sequences cannot reach. For that reason the V flag is compared against the bench's own reference model and is never forced.

// File: rtl/imm_exec_pkg.sv
package imm_exec_pkg;

    localparam int INSTR_W  = 16;
    localparam int DATA_W   = 32;
    localparam int IMM_W    = 8;
    localparam int REG_AW   = 3;
    localparam int NUM_REGS = 1 << REG_AW;
    localparam int OP_W     = 2;
    localparam int TAG_W    = 3;

    localparam int TAG_LSB  = INSTR_W - TAG_W;
    localparam int OP_LSB   = TAG_LSB - OP_W;
    localparam int RD_LSB   = OP_LSB - REG_AW;

    localparam logic [TAG_W-1:0] FMT_TAG = 3'b001;

    typedef enum logic [OP_W-1:0] {
        OP_MOV = 2'd0,
        OP_CMP = 2'd1,
        OP_ADD = 2'd2,
        OP_SUB = 2'd3
    } imm_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } cc_t;

    typedef struct packed {
        logic              legal;
        imm_op_e           op;
        logic [REG_AW-1:0] rd;
        logic [IMM_W-1:0]  imm;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        cc_t               cc;
        logic              write_rd;
    } alu_out_t;

    function automatic logic [DATA_W-1:0] zext_imm(input logic [IMM_W-1:0] lit);
        return {{(DATA_W-IMM_W){1'b0}}, lit};
    endfunction

endpackage

// File: rtl/imm_exec_decode.sv
module imm_exec_decode
    import imm_exec_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);

    always_comb begin
        dec.legal = (instr[TAG_LSB +: TAG_W] == FMT_TAG);
        dec.op    = imm_op_e'(instr[OP_LSB +: OP_W]);
        dec.rd    = instr[RD_LSB +: REG_AW];
        dec.imm   = instr[IMM_W-1:0];
    end

endmodule

// File: rtl/imm_exec_alu.sv
module imm_exec_alu
    import imm_exec_pkg::*;
(
    input  imm_op_e           op,
    input  logic [DATA_W-1:0] src,
    input  logic [IMM_W-1:0]  imm,
    input  cc_t               cc_in,
    output alu_out_t          res
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] opnd;
    logic [DATA_W:0]   sum_w;
    logic [DATA_W:0]   dif_w;

    always_comb begin
        opnd  = zext_imm(imm);
        sum_w = {1'b0, src} + {1'b0, opnd};
        dif_w = {1'b0, src} + {1'b0, ~opnd} + {{DATA_W{1'b0}}, 1'b1};

        res          = '0;
        res.write_rd = (op != OP_CMP);
        unique case (op)
            OP_MOV: begin
                res.value = opnd;
                res.cc.c  = cc_in.c;
                res.cc.v  = cc_in.v;
            end
            OP_ADD: begin
                res.value = sum_w[MSB:0];
                res.cc.c  = sum_w[DATA_W];
                res.cc.v  = (src[MSB] == opnd[MSB]) && (sum_w[MSB] != src[MSB]);
            end
            default: begin
                res.value = dif_w[MSB:0];
                res.cc.c  = dif_w[DATA_W];
                res.cc.v  = (src[MSB] != opnd[MSB]) && (dif_w[MSB] != src[MSB]);
            end
        endcase
        res.cc.n = res.value[MSB];
        res.cc.z = (res.value == '0);
    end

endmodule

// File: rtl/imm_exec_regs.sv
module imm_exec_regs #(
    parameter int DATA_W = 32,
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [REG_AW-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_data
);

    localparam int NREG = 1 << REG_AW;

    logic [DATA_W-1:0] bank [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && (wr_addr == REG_AW'(g))) begin
                q <= wr_data;
            end
        end
        assign bank[g] = q;
    end

    assign ra_data = bank[ra_addr];
    assign rb_data = bank[rb_addr];

endmodule

// File: rtl/imm_exec_unit.sv
module imm_exec_unit
    import imm_exec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] in_instr,
    output logic               illegal,
    input  logic [REG_AW-1:0]  rd_sel,
    output logic [DATA_W-1:0]  rd_data,
    output logic [3:0]         flags_o
);

    dec_t              dec;
    alu_out_t          alu;
    cc_t               cc_q;
    logic [DATA_W-1:0] src_val;
    logic              fire;
    logic              ill_q;

    imm_exec_decode u_dec (
        .instr (in_instr),
        .dec   (dec)
    );

    assign fire = in_valid && dec.legal;

    imm_exec_regs #(
        .DATA_W (DATA_W),
        .REG_AW (REG_AW)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (fire && alu.write_rd),
        .wr_addr (dec.rd),
        .wr_data (alu.value),
        .ra_addr (dec.rd),
        .ra_data (src_val),
        .rb_addr (rd_sel),
        .rb_data (rd_data)
    );

    imm_exec_alu u_alu (
        .op    (dec.op),
        .src   (src_val),
        .imm   (dec.imm),
        .cc_in (cc_q),
        .res   (alu)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cc_q  <= '0;
            ill_q <= 1'b0;
        end else begin
            ill_q <= in_valid && !dec.legal;
            if (fire) begin
                cc_q <= alu.cc;
            end
        end
    end

    assign illegal = ill_q;
    assign flags_o = cc_q;

endmodule

// File: rtl/imm_exec_unit_chk.sv
module imm_exec_unit_chk
    import imm_exec_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [INSTR_W-1:0] in_instr,
    input logic               illegal,
    input logic [3:0]         flags_o
);

    logic tag_ok;
    logic is_mov;
    assign tag_ok = (in_instr[TAG_LSB +: TAG_W] == FMT_TAG);
    assign is_mov = (in_instr[OP_LSB +: OP_W] == OP_MOV);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (flags_o == 4'b0000 && !illegal));

    assert_bad_tag_flags_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !tag_ok) |=> (illegal && $stable(flags_o)));

    assert_good_tag_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (!in_valid || tag_ok) |=> !illegal);

    assert_mov_keeps_cv_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && tag_ok && is_mov) |=> (flags_o[1:0] == $past(flags_o[1:0]) && !flags_o[3]));

    assert_mov_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && tag_ok && is_mov && in_instr[IMM_W-1:0] == '0) |=> flags_o[2]);

    assert_idle_flags_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(flags_o));

endmodule

bind imm_exec_unit imm_exec_unit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_instr (in_instr),
    .illegal  (illegal),
    .flags_o  (flags_o)
);

// File: tb/imm_exec_unit_test.sv
`timescale 1ns/100ps
module imm_exec_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_instr = 16'h0000;
    logic        illegal;
    logic [2:0]  rd_sel = 3'd0;
    logic [31:0] rd_data;
    logic [3:0]  flags_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] m_reg [8];
    logic [3:0]  m_cc;
    logic        m_ill;

    always #2.5 clk = ~clk;

    imm_exec_unit uut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_instr (in_instr),
        .illegal  (illegal),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .flags_o  (flags_o)
    );

    function automatic logic [15:0] enc(input logic [1:0] op, input logic [2:0] rd, input logic [7:0] lit);
        return {3'b001, op, rd, lit};
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        m_cc  = '0;
        m_ill = 1'b0;
    endfunction

    function automatic void model_step(input logic [15:0] ins);
        logic [31:0] a, b, r;
        logic [32:0] s;
        logic c, v;
        if (ins[15:13] != 3'b001) begin
            m_ill = 1'b1;
            return;
        end
        m_ill = 1'b0;
        a = m_reg[ins[10:8]];
        b = {24'd0, ins[7:0]};
        case (ins[12:11])
            2'd0: begin r = b; c = m_cc[1]; v = m_cc[0]; end
            2'd2: begin s = {1'b0, a} + {1'b0, b}; r = s[31:0]; c = s[32];
                        v = (a[31] == b[31]) && (r[31] != a[31]); end
            default: begin r = a - b; c = (a >= b);
                        v = (a[31] != b[31]) && (r[31] != a[31]); end
        endcase
        m_cc = {r[31], r == 32'd0, c, v};
        if (ins[12:11] != 2'd1) m_reg[ins[10:8]] = r;
    endfunction

    task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 8; i++) begin
            rd_sel = 3'(i);
            #0.2;
            cmp(rd_data, m_reg[i], $sformatf("%s reg%0d", tag, i));
        end
        cmp({28'd0, flags_o}, {28'd0, m_cc}, {tag, " flags"});
        cmp({31'd0, illegal}, {31'd0, m_ill}, {tag, " illegal"});
    endtask

    task automatic peek(input logic [2:0] idx, input logic [31:0] exp, input string tag);
        rd_sel = idx;
        #0.2;
        cmp(rd_data, exp, tag);
    endtask

    task automatic exec(input logic [15:0] ins);
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = ins;
        @(negedge clk);
        in_valid = 1'b0;
        model_step(ins);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_all("R1 reset");
    endtask

    task automatic t_move();
        exec(enc(2'd0, 3'd0, 8'd128));
        check_all("R3 mov 128");
        peek(3'd0, 32'd128, "R9 literal 128 zero-extended");
        cmp({28'd0, flags_o}, 32'h0, "R11 flags after mov 128");
        exec(enc(2'd3, 3'd1, 8'd0));
        check_all("R5 sub zero sets C");
        exec(enc(2'd0, 3'd2, 8'd0));
        check_all("R3 mov zero keeps C");
        cmp({28'd0, flags_o}, 32'h6, "R3 mov zero Z=1 C kept");
        exec(enc(2'd0, 3'd3, 8'd5));
        cmp({28'd0, flags_o}, 32'h2, "R3 mov nonzero C kept");
    endtask

    task automatic t_add();
        exec(enc(2'd2, 3'd1, 8'd255));
        check_all("R4 add 255");
        peek(3'd1, 32'd255, "R9 literal 255 positive");
        exec(enc(2'd3, 3'd4, 8'd1));
        check_all("R5 sub wraps negative");
        cmp({28'd0, flags_o}, 32'h8, "R5 N set C clear");
        exec(enc(2'd2, 3'd4, 8'd1));
        check_all("R4 add carry out to zero");
        cmp({28'd0, flags_o}, 32'h6, "R4 Z and C set");
    endtask

    task automatic t_sub();
        exec(enc(2'd0, 3'd5, 8'd10));
        exec(enc(2'd3, 3'd5, 8'd3));
        check_all("R5 sub no borrow");
        peek(3'd5, 32'd7, "R5 7 left");
        exec(enc(2'd3, 3'd5, 8'd200));
        check_all("R5 sub with borrow");
        peek(3'd5, 32'hFFFFFF3F, "R5 wrapped value");
    endtask

    task automatic t_compare();
        exec(enc(2'd0, 3'd6, 8'd62));
        exec(enc(2'd1, 3'd6, 8'd62));
        check_all("R6 cmp equal");
        cmp({28'd0, flags_o}, 32'h6, "R6 equal Z C");
        peek(3'd6, 32'd62, "R6 reg kept");
        exec(enc(2'd1, 3'd6, 8'd145));
        check_all("R6 cmp below");
        peek(3'd6, 32'd62, "R6 reg kept after below");
    endtask

    task automatic t_regsel();
        for (int i = 0; i < 8; i++) exec(enc(2'd0, 3'(i), 8'(17 * i + 3)));
        check_all("R7 each register");
        exec(enc(2'd2, 3'd3, 8'd100));
        check_all("R7 single target");
    endtask

    task automatic t_illegal();
        exec(16'h0000);
        check_all("R2 tag 000");
        exec(16'hE7FF);
        check_all("R2 tag 111");
        exec(16'h5AAA);
        check_all("R2 tag 010");
        exec(enc(2'd2, 3'd0, 8'd1));
        check_all("R2 legal after illegal");
    endtask

    task automatic t_idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_instr = enc(2'd0, 3'd0, 8'd0);
        repeat (3) @(negedge clk);
        in_instr = 16'h0000;
        repeat (2) @(negedge clk);
        m_ill = 1'b0;
        check_all("R8 no strobe");
    endtask

    task automatic t_back2back();
        logic [15:0] seq [5];
        seq[0] = enc(2'd0, 3'd7, 8'd50);
        seq[1] = enc(2'd2, 3'd7, 8'd50);
        seq[2] = enc(2'd3, 3'd7, 8'd99);
        seq[3] = enc(2'd1, 3'd7, 8'd1);
        seq[4] = enc(2'd3, 3'd7, 8'd2);
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = seq[0];
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            model_step(seq[k]);
            check_all($sformatf("R10 step %0d", k));
            if (k < 4) in_instr = seq[k + 1];
            else in_valid = 1'b0;
        end
        peek(3'd7, 32'hFFFFFFFF, "R10 chained result");
    endtask

    initial begin
        model_reset();
        t_reset();
        t_move();
        t_add();
        t_sub();
        t_compare();
        t_regsel();
        t_illegal();
        t_idle();
        t_back2back();
        t_reset();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule